// File: doc/BRIEF.md
# Queued Word-Aligned DMA Engine

This block moves blocks of 32-bit words out of memory. Software loads a source address, a destination address and a source length through a small register write port. It then writes the destination length. That last write takes a snapshot of all four values as one command and places it in a command queue of parameterised depth. Commands run strictly in the order they were queued. Each command is cut into chunks of at most 1024 bytes, and every chunk is issued as a run of single-word memory reads at rising, consecutive addresses.

Each command runs in one of two ways. In loopback mode, every word that is read is written back to memory at the matching position of the destination region. Otherwise, every word read is handed to an output stream port for a downstream consumer, and the destination length plays no part. A finished command sets two sticky completion flags. A command that arrives while the queue is full is dropped and sets an overflow flag. Queue full and queue empty are shown on a status word.

Top module: `qword_dma`

## Requirements
- R1: A write to register index 3 queues one command. The command holds the source address last written to index 0, the destination address last written to index 1, the source length last written to index 2, and the destination length carried by this write.
- R2: The command clears the two low bits of both addresses, so every memory request address is a multiple of 4.
- R3: Lengths count 32-bit words. Only bits 26:0 of a length write are kept, and bits 31:27 are ignored. The byte count is the word count times 4.
- R4: Each chunk is the smallest of 1024 bytes, the remaining source bytes and, in loopback mode only, the remaining destination bytes. A chunk is issued as single-word reads at consecutive addresses, and the following chunk continues where this one stopped.
- R5: In loopback mode, each word read from source offset k is written to destination offset k. Outside loopback mode, each word read is presented on the stream port, no memory write is issued, and the destination length is ignored.
- R6: A command finishes when its next chunk would be zero bytes long. A command with zero length therefore finishes without any memory access. On finishing, int_status bits 13 and 12 are set and the command leaves the queue.
- R7: Queued commands are run one after another in queue order until the queue is empty.
- R8: status_word bit 31 is 1 when DEPTH commands are held, counting the one in progress. Bit 30 is 1 when the queue is empty. After reset, status_word is 0x40000000.
- R9: A write to index 3 while the queue is full drops the command and sets int_status bit 14.
- R10: Loopback mode is taken from loopback_en in the cycle a command starts. Later changes to loopback_en do not affect a command that has already started.
- R11: A write to index 4 clears every int_status bit whose matching data bit is 1. If a flag is set and cleared in the same cycle, setting wins. irq is the OR of all int_status bits. After reset, int_status is 0 and irq is 0.
- R12: A memory request keeps its valid, address, write enable and data steady until mem_ready is seen. Read data is taken in the cycle mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 source address, 1 destination address, 2 source length, 3 destination length (queues a command), 4 flag clear |
| reg_wdata | input | 32 | Register write data |
| loopback_en | input | 1 | Loopback select, sampled when a command starts |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory request byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_ready | input | 1 | Stream consumer accepts the word |
| status_word | output | 32 | Bit 31 queue full, bit 30 queue empty |
| int_status | output | 32 | Bit 14 overflow, bit 13 done, bit 12 partial done |
| irq | output | 1 | OR of int_status |

## Verification
The assertions assume a well-behaved memory. It must return exactly one mem_rvalid for each accepted read, and only after that read was accepted. It must never raise mem_rvalid when no read is waiting. The bench's memory responder works this way. It logs a request in the half cycle before the accepting edge, and it drives one response pulse in the following cycle. It stalls only by holding mem_ready low, never by dropping or repeating a response. Register writes are always one-cycle strobes driven away from the clock edge, and the stream consumer is always ready.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    parameter int ADDR_W    = 32;
    parameter int DATA_W    = 32;
    parameter int LEN_W     = 27;
    parameter int CHUNK_MAX = 1024;

    localparam int BYTES_W = LEN_W + 2;
    localparam int CHUNK_W = $clog2(CHUNK_MAX) + 1;
    localparam int BEAT_W  = CHUNK_W - 2;

    localparam int INT_PDONE = 12;
    localparam int INT_DONE  = 13;
    localparam int INT_OVF   = 14;
    localparam int ST_FULL   = 31;
    localparam int ST_EMPTY  = 30;

    typedef enum logic [2:0] {
        RIDX_SRC  = 3'd0,
        RIDX_DST  = 3'd1,
        RIDX_SLEN = 3'd2,
        RIDX_DLEN = 3'd3,
        RIDX_ICLR = 3'd4
    } qdma_ridx_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  dst;
        logic [BYTES_W-1:0] src_bytes;
        logic [BYTES_W-1:0] dst_bytes;
    } qdma_cmd_t;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_STEP,
        MV_RD,
        MV_RWAIT,
        MV_WR,
        MV_PUSH,
        MV_FIN
    } mover_state_e;

    function automatic logic [CHUNK_W-1:0] chunk_step(
        input logic [BYTES_W-1:0] s_left,
        input logic [BYTES_W-1:0] d_left,
        input logic               lp
    );
        logic [BYTES_W-1:0] m;
        m = s_left;
        if (lp && (d_left < m)) m = d_left;
        if (m > BYTES_W'(CHUNK_MAX)) m = BYTES_W'(CHUNK_MAX);
        return m[CHUNK_W-1:0];
    endfunction

endpackage

// File: rtl/qdma_cmd_fifo.sv
module qdma_cmd_fifo
    import qdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  qdma_cmd_t push_cmd,
    input  logic      pop,
    output qdma_cmd_t head,
    output logic      full,
    output logic      empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    qdma_cmd_t          slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_cmd;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R9
    AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R6
    AST_FIFO_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));  // R8

endmodule

// File: rtl/qdma_mover.sv
module qdma_mover
    import qdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_avail,
    input  qdma_cmd_t         head_cmd,
    input  logic              loopback_en,
    output logic              cmd_done,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              st_valid,
    output logic [DATA_W-1:0] st_data,
    input  logic              st_ready
);
    mover_state_e        state;
    logic [ADDR_W-1:0]   cur_src, cur_dst, rd_ptr, wr_ptr;
    logic [BYTES_W-1:0]  src_left, dst_left;
    logic                lpbk;
    logic [CHUNK_W-1:0]  chunk;
    logic [BEAT_W-1:0]   beats;
    logic [DATA_W-1:0]   data_q;
    logic [CHUNK_W-1:0]  step_now;
    logic                beat_ok;

    assign step_now = chunk_step(src_left, dst_left, lpbk);
    assign beat_ok  = ((state == MV_WR) && mem_ready) || ((state == MV_PUSH) && st_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MV_IDLE;
            cur_src  <= '0;
            cur_dst  <= '0;
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            src_left <= '0;
            dst_left <= '0;
            lpbk     <= 1'b0;
            chunk    <= '0;
            beats    <= '0;
            data_q   <= '0;
        end else begin
            case (state)
                MV_IDLE: if (cmd_avail) begin
                    cur_src  <= head_cmd.src;
                    cur_dst  <= head_cmd.dst;
                    src_left <= head_cmd.src_bytes;
                    dst_left <= head_cmd.dst_bytes;
                    lpbk     <= loopback_en;
                    state    <= MV_STEP;
                end
                MV_STEP: begin
                    if (step_now == '0) begin
                        state <= MV_FIN;
                    end else begin
                        chunk  <= step_now;
                        beats  <= step_now[CHUNK_W-1:2];
                        rd_ptr <= cur_src;
                        wr_ptr <= cur_dst;
                        state  <= MV_RD;
                    end
                end
                MV_RD: if (mem_ready) state <= MV_RWAIT;
                MV_RWAIT: if (mem_rvalid) begin
                    data_q <= mem_rdata;
                    state  <= lpbk ? MV_WR : MV_PUSH;
                end
                MV_WR, MV_PUSH: if (beat_ok) begin
                    rd_ptr <= rd_ptr + ADDR_W'(4);
                    wr_ptr <= wr_ptr + ADDR_W'(4);
                    beats  <= beats - 1'b1;
                    if (beats == BEAT_W'(1)) begin
                        cur_src  <= cur_src + ADDR_W'(chunk);
                        src_left <= src_left - BYTES_W'(chunk);
                        if (lpbk) begin
                            cur_dst  <= cur_dst + ADDR_W'(chunk);
                            dst_left <= dst_left - BYTES_W'(chunk);
                        end
                        state <= MV_STEP;
                    end else begin
                        state <= MV_RD;
                    end
                end
                MV_FIN: state <= MV_IDLE;
                default: state <= MV_IDLE;
            endcase
        end
    end

    assign mem_valid = (state == MV_RD) || (state == MV_WR);
    assign mem_we    = (state == MV_WR);
    assign mem_addr  = (state == MV_WR) ? wr_ptr : rd_ptr;
    assign mem_wdata = data_q;
    assign st_valid  = (state == MV_PUSH);
    assign st_data   = data_q;
    assign cmd_done  = (state == MV_FIN);

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R12
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));  // R2
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == MV_RD) |-> (chunk != '0 && chunk <= CHUNK_W'(CHUNK_MAX) && chunk[1:0] == 2'b00));  // R4
    AST_NO_WRITE_OUTSIDE_LPBK: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we) |-> lpbk);  // R5

endmodule

// File: rtl/qword_dma.sv
module qword_dma
    import qdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    input  logic        loopback_en,
    output logic        mem_valid,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        st_valid,
    output logic [31:0] st_data,
    input  logic        st_ready,
    output logic [31:0] status_word,
    output logic [31:0] int_status,
    output logic        irq
);
    logic [ADDR_W-1:0] r_src, r_dst;
    logic [LEN_W-1:0]  r_slen;
    logic              wr_dlen, wr_iclr;
    logic              q_push, q_pop, q_full, q_empty;
    qdma_cmd_t         new_cmd, head_cmd;
    logic              f_ovf, f_done, f_pdone;
    logic              unused_wdata;

    assign wr_dlen = reg_wr && (reg_idx == RIDX_DLEN);
    assign wr_iclr = reg_wr && (reg_idx == RIDX_ICLR);
    assign q_push  = wr_dlen && !q_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_src  <= '0;
            r_dst  <= '0;
            r_slen <= '0;
        end else if (reg_wr) begin
            case (reg_idx)
                RIDX_SRC:  r_src  <= reg_wdata;
                RIDX_DST:  r_dst  <= reg_wdata;
                RIDX_SLEN: r_slen <= reg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        new_cmd.src       = {r_src[ADDR_W-1:2], 2'b00};
        new_cmd.dst       = {r_dst[ADDR_W-1:2], 2'b00};
        new_cmd.src_bytes = {r_slen, 2'b00};
        new_cmd.dst_bytes = {reg_wdata[LEN_W-1:0], 2'b00};
    end

    assign unused_wdata = ^reg_wdata[31:LEN_W];

    qdma_cmd_fifo #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_cmd (new_cmd),
        .pop      (q_pop),
        .head     (head_cmd),
        .full     (q_full),
        .empty    (q_empty)
    );

    qdma_mover u_mover (
        .clk         (clk),
        .rst         (rst),
        .cmd_avail   (!q_empty),
        .head_cmd    (head_cmd),
        .loopback_en (loopback_en),
        .cmd_done    (q_pop),
        .mem_valid   (mem_valid),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ready   (mem_ready),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .st_valid    (st_valid),
        .st_data     (st_data),
        .st_ready    (st_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            f_ovf   <= 1'b0;
            f_done  <= 1'b0;
            f_pdone <= 1'b0;
        end else begin
            f_ovf   <= (wr_dlen && q_full) || (f_ovf   && !(wr_iclr && reg_wdata[INT_OVF]));
            f_done  <= q_pop               || (f_done  && !(wr_iclr && reg_wdata[INT_DONE]));
            f_pdone <= q_pop               || (f_pdone && !(wr_iclr && reg_wdata[INT_PDONE]));
        end
    end

    always_comb begin
        int_status            = '0;
        int_status[INT_OVF]   = f_ovf;
        int_status[INT_DONE]  = f_done;
        int_status[INT_PDONE] = f_pdone;
        status_word           = '0;
        status_word[ST_FULL]  = q_full;
        status_word[ST_EMPTY] = q_empty;
    end

    assign irq = f_ovf || f_done || f_pdone;

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        q_pop |=> (int_status[INT_DONE] && int_status[INT_PDONE]));  // R6
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_dlen && q_full) |=> int_status[INT_OVF]);  // R9
    AST_FULL_HOLDS_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_dlen && q_full && !q_pop) |=> status_word[ST_FULL]);  // R8

endmodule

// File: tb/qword_dma_tb.sv
module qword_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        loopback_en = 1'b0;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        st_valid;
    logic [31:0] st_data;
    logic        st_ready = 1'b1;
    logic [31:0] status_word, int_status;
    logic        irq;
    logic        stall = 1'b0;

    assign mem_ready = !stall;

    always #2.5 clk = ~clk;

    qword_dma #(.DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .loopback_en(loopback_en), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .st_valid(st_valid),
        .st_data(st_data), .st_ready(st_ready), .status_word(status_word),
        .int_status(int_status), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    int n_rd, n_wr, n_st, mism;
    logic [31:0] first_rd, last_rd, last_wr, first_wr;
    logic [31:0] rd_log [8];
    logic        pend = 1'b0;
    logic [31:0] pend_addr;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    // memory and stream observer, acting between clock edges
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = pat(pend_addr);
            pend       = 1'b0;
        end
        if (mem_valid && mem_ready && !mem_we) begin
            if (n_rd < 8) rd_log[n_rd] = mem_addr;
            if (n_rd == 0) first_rd = mem_addr;
            last_rd   = mem_addr;
            pend      = 1'b1;
            pend_addr = mem_addr;
            n_rd++;
        end
        if (mem_valid && mem_ready && mem_we) begin
            if (n_wr == 0) first_wr = mem_addr;
            if (mem_wdata != pat(last_rd)) mism++;
            if ((mem_addr - first_wr) != (last_rd - first_rd)) mism++;
            last_wr = mem_addr;
            n_wr++;
        end
        if (st_valid && st_ready) begin
            if (st_data != pat(last_rd)) mism++;
            n_st++;
        end
    end

    task automatic clear_log();
        n_rd = 0; n_wr = 0; n_st = 0; mism = 0;
        first_rd = '0; last_rd = '0; last_wr = '0; first_wr = '0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic enqueue(input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] sl, input logic [31:0] dl);
        wr_reg(3'd0, s);
        wr_reg(3'd1, d);
        wr_reg(3'd2, sl);
        wr_reg(3'd3, dl);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((status_word[30] !== 1'b1 || int_status[13] !== 1'b1) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] slen;
        logic [31:0] dlen;
        logic        lp;
        logic [15:0] n_rd;
        logic [15:0] n_wr;
        logic [31:0] first_rd;
        logic [31:0] last_rd;
        logic [31:0] last_wr;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 32'h0000_8000, 32'd4,          32'd0,  1'b0, 16'd4,   16'd0,   32'h1000, 32'h100C, 32'h0},
        '{32'h0000_2003, 32'h0000_8000, 32'd300,        32'd0,  1'b0, 16'd300, 16'd0,   32'h2000, 32'h24AC, 32'h0},
        '{32'h0000_3000, 32'h0000_9001, 32'd10,         32'd10, 1'b1, 16'd10,  16'd10,  32'h3000, 32'h3024, 32'h9024},
        '{32'h0000_4000, 32'h0000_A000, 32'd8,          32'd5,  1'b1, 16'd5,   16'd5,   32'h4000, 32'h4010, 32'hA010},
        '{32'h0000_5000, 32'h0000_A000, 32'd0,          32'd0,  1'b0, 16'd0,   16'd0,   32'h0,    32'h0,    32'h0},
        '{32'h0000_6000, 32'h0000_A000, 32'hF800_0003,  32'd0,  1'b0, 16'd3,   16'd0,   32'h6000, 32'h6008, 32'h0},
        '{32'h0000_7000, 32'h0000_B000, 32'd2,          32'd7,  1'b0, 16'd2,   16'd0,   32'h7000, 32'h7004, 32'h0},
        '{32'h0000_C000, 32'h0000_E000, 32'd260,        32'd300,1'b1, 16'd260, 16'd260, 32'hC000, 32'hC40C, 32'hE40C}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        clear_log();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state: R8, R11
        check("R8 reset status", status_word, 32'h4000_0000);
        check("R11 reset int_status", int_status, 32'h0);
        check("R11 reset irq", {31'b0, irq}, 32'h0);
        check("R12 reset no request", {30'b0, mem_valid, st_valid}, 32'h0);

        // table-driven transfers: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            clear_log();
            loopback_en = VECS[i].lp;
            enqueue(VECS[i].src, VECS[i].dst, VECS[i].slen, VECS[i].dlen);
            wait_idle();
            check($sformatf("R4 vec%0d read beats", i), n_rd, 32'(VECS[i].n_rd));
            check($sformatf("R5 vec%0d write beats", i), n_wr, 32'(VECS[i].n_wr));
            check($sformatf("R5 vec%0d stream words", i), n_st,
                  VECS[i].lp ? 32'd0 : 32'(VECS[i].n_rd));
            check($sformatf("R5 vec%0d data match", i), mism, 32'd0);
            if (VECS[i].n_rd != 0) begin
                check($sformatf("R2 vec%0d first read", i), first_rd, VECS[i].first_rd);
                check($sformatf("R3 vec%0d last read", i), last_rd, VECS[i].last_rd);
            end
            if (VECS[i].n_wr != 0)
                check($sformatf("R1 vec%0d last write", i), last_wr, VECS[i].last_wr);
            check($sformatf("R6 vec%0d done flags", i), int_status & 32'h3000, 32'h3000);
            wr_reg(3'd4, 32'h0000_7000);
            @(negedge clk);
            check($sformatf("R11 vec%0d cleared", i), int_status, 32'h0);
        end
        loopback_en = 1'b0;

        // queue fill, overflow, ordering: R7 R8 R9 R11
        clear_log();
        stall = 1'b1;
        for (int k = 1; k <= 4; k++) enqueue(32'h100 * k, 32'h0, 32'd1, 32'd0);
        @(negedge clk);
        check("R8 queue full", status_word, 32'h8000_0000);
        enqueue(32'h500, 32'h0, 32'd1, 32'd0);
        @(negedge clk);
        check("R9 overflow flag", int_status, 32'h0000_4000);
        check("R8 still full after drop", status_word, 32'h8000_0000);
        check("R11 irq from overflow", {31'b0, irq}, 32'h1);
        stall = 1'b0;
        wait_idle();
        check("R9 dropped command not run", n_rd, 32'd4);
        for (int k = 0; k < 4; k++)
            check($sformatf("R7 order slot%0d", k), rd_log[k], 32'h100 * (k + 1));
        check("R6 all flags after queue drain", int_status, 32'h0000_7000);
        wr_reg(3'd4, 32'h0000_4000);
        @(negedge clk);
        check("R11 partial clear", int_status, 32'h0000_3000);
        wr_reg(3'd4, 32'h0000_3000);
        @(negedge clk);
        check("R11 full clear irq", {31'b0, irq}, 32'h0);

        // loopback sampled at start: R10
        clear_log();
        stall = 1'b1;
        loopback_en = 1'b0;
        enqueue(32'hD000, 32'hF000, 32'd2, 32'd2);
        repeat (4) @(negedge clk);
        loopback_en = 1'b1;
        stall = 1'b0;
        wait_idle();
        check("R10 no writes after late loopback", n_wr, 32'd0);
        check("R10 stream words", n_st, 32'd2);
        loopback_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule